// File: doc/BRIEF.md
# Fixed-Point Multiply-Accumulate Datapath

This block is the arithmetic core of a small 16-bit fixed-point signal processor. Operands reach the multiplier only through two dedicated 16-bit input registers. A signed 16x16 multiplier writes a 32-bit product register. A 36-bit ALU then adds that product to, or subtracts it from, one of two 36-bit accumulators. The four guard bits above the product absorb growth across long sums. A shifter moves the selected accumulator one or four bit positions in either direction.

A sequencer outside the block drives a 3-bit operation code on every clock. Each code takes effect at the next rising edge. The product register sits between the multiplier and the ALU as a pipeline stage, so a multiply and an accumulate can be issued in the same cycle. A mode input selects fractional (Q15 x Q15 -> Q31) or integer products. A read-select input steers one accumulator, and its middle 16-bit word, to the output.

Top module: `dsp_mac_datapath`

## Requirements
- R1: A synchronous active-high reset clears both input registers, the product register and both accumulators to zero.
- R2: Operation code 1 (LOAD) writes `operand_i` into the X input register when `opnd_sel_i`=0, or into the Y register when it is 1. The multiplier reads only these registers, so a change on `operand_i` without a LOAD has no effect on later products.
- R3: Operation code 2 (MUL) with `frac_i`=0 stores the signed 32-bit product X*Y in the product register.
- R4: MUL with `frac_i`=1 stores the product shifted left by one bit. The case 0x8000 x 0x8000 is the exception and stores 0x7FFFFFFF.
- R5: Code 3 (MAC) adds the product register, sign-extended to 36 bits, to the accumulator picked by `acc_sel_i` (0 = A0, 1 = A1). Code 4 (MSU) subtracts it instead. Results wrap modulo 2^36.
- R6: An operation changes only the accumulator that `acc_sel_i` selects. The other accumulator keeps its value.
- R7: Code 5 (SHIFT) with `shl_i`=0 shifts the selected accumulator right arithmetically, which keeps its sign. The shift is by 4 when `by4_i`=1 and by 1 otherwise.
- R8: SHIFT with `shl_i`=1 shifts the selected accumulator left by 1 or 4 and fills with zeros. Bits pushed past bit 35 are lost.
- R9: Code 7 (MAC+MUL) adds the product register value from before the edge to the selected accumulator. In the same cycle it loads the product register with the new X*Y. The product register changes only on codes 2 and 7.
- R10: Code 6 (CLEAR) sets the selected accumulator to zero. Code 0 is a no-operation.
- R11: `acc_o` shows all 36 bits of the accumulator chosen by `rd_sel_i`, and `acc_hi_o` shows bits 31:16 of that accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation code, applied at the next edge |
| acc_sel_i | input | 1 | Target accumulator (0 = A0, 1 = A1) |
| frac_i | input | 1 | 1 = fractional product, 0 = integer product |
| opnd_sel_i | input | 1 | LOAD target (0 = X, 1 = Y) |
| operand_i | input | 16 | Operand for LOAD |
| shl_i | input | 1 | Shift direction (1 = left) |
| by4_i | input | 1 | Shift amount (1 = four bits, 0 = one bit) |
| rd_sel_i | input | 1 | Accumulator shown on the outputs |
| acc_o | output | 36 | Full selected accumulator |
| acc_hi_o | output | 16 | Bits 31:16 of the selected accumulator |

## Verification
Wrap-around of the 36-bit ALU is the hardest condition to reach from the ports. A single product cannot come near bit 35. The bench builds the saturated fractional product 0x7FFFFFFF and shifts it left by four so the accumulator sits just below 2^35. One more MAC then crosses into the sign bit. Further left shifts push bits out of the top. The pipeline overlap is tested by changing the operands between a MUL and a MAC+MUL, which makes the old and new product values distinct.

// File: rtl/dsp_mac_pkg.sv
package dsp_mac_pkg;

    localparam int DW  = 16;
    localparam int GW  = 4;
    localparam int PW  = 2 * DW;
    localparam int AW  = PW + GW;

    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_LOAD   = 3'd1,
        OP_MUL    = 3'd2,
        OP_MAC    = 3'd3,
        OP_MSU    = 3'd4,
        OP_SHIFT  = 3'd5,
        OP_CLR    = 3'd6,
        OP_MACMUL = 3'd7
    } op_e;

    typedef struct packed {
        logic left;
        logic by4;
    } shift_ctl_t;

    // signed product, optionally in Q31 with the single overflow case clamped
    function automatic logic [PW-1:0] mul_fix(input logic [DW-1:0] a,
                                              input logic [DW-1:0] b,
                                              input logic frac);
        logic signed [PW-1:0] raw;
        logic [DW-1:0]        most_neg;
        most_neg = {1'b1, {(DW-1){1'b0}}};
        raw = PW'($signed(a)) * PW'($signed(b));
        if (!frac)
            return raw;
        else if (a == most_neg && b == most_neg)
            return {1'b0, {(PW-1){1'b1}}};
        else
            return raw <<< 1;
    endfunction

    function automatic logic [AW-1:0] widen(input logic [PW-1:0] p);
        return {{GW{p[PW-1]}}, p};
    endfunction

endpackage

// File: rtl/dsp_mul_stage.sv
module dsp_mul_stage
    import dsp_mac_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          load_en,
    input  logic          load_y,
    input  logic [DW-1:0] operand,
    input  logic          mul_en,
    input  logic          frac,
    output logic [DW-1:0] x_q,
    output logic [DW-1:0] y_q,
    output logic [PW-1:0] prod_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q    <= '0;
            y_q    <= '0;
            prod_q <= '0;
        end else begin
            if (load_en && !load_y) x_q <= operand;
            if (load_en &&  load_y) y_q <= operand;
            if (mul_en)             prod_q <= mul_fix(x_q, y_q, frac);
        end
    end

endmodule

// File: rtl/dsp_shifter.sv
module dsp_shifter
    import dsp_mac_pkg::*;
#(
    parameter int SMALL = 1,
    parameter int LARGE = 4
) (
    input  logic [AW-1:0] din,
    input  shift_ctl_t    ctl,
    output logic [AW-1:0] dout
);

    localparam int CW = $clog2(LARGE + 1);
    logic [CW-1:0] amt;

    always_comb begin
        amt = ctl.by4 ? CW'(LARGE) : CW'(SMALL);
        if (ctl.left)
            dout = din << amt;
        else
            dout = $signed(din) >>> amt;
    end

endmodule

// File: rtl/dsp_acc_bank.sv
module dsp_acc_bank
    import dsp_mac_pkg::*;
#(
    parameter int NACC = 2,
    parameter int SW   = (NACC > 1) ? $clog2(NACC) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  op_e                      op,
    input  logic [SW-1:0]            sel,
    input  logic [PW-1:0]            prod,
    input  shift_ctl_t               sh,
    output logic [NACC-1:0][AW-1:0]  acc_o
);

    logic [AW-1:0] acc_q [NACC];
    logic [AW-1:0] src;
    logic [AW-1:0] shifted;
    logic [AW-1:0] pext;

    assign src  = acc_q[sel];
    assign pext = widen(prod);

    dsp_shifter u_shift (
        .din  (src),
        .ctl  (sh),
        .dout (shifted)
    );

    for (genvar i = 0; i < NACC; i++) begin : g_acc
        always_ff @(posedge clk) begin
            if (rst) begin
                acc_q[i] <= '0;
            end else if (sel == SW'(i)) begin
                case (op)
                    OP_MAC,
                    OP_MACMUL: acc_q[i] <= acc_q[i] + pext;
                    OP_MSU:    acc_q[i] <= acc_q[i] - pext;
                    OP_SHIFT:  acc_q[i] <= shifted;
                    OP_CLR:    acc_q[i] <= '0;
                    default:   acc_q[i] <= acc_q[i];
                endcase
            end
        end
        assign acc_o[i] = acc_q[i];
    end

endmodule

// File: rtl/dsp_mac_datapath.sv
module dsp_mac_datapath
    import dsp_mac_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  op_i,
    input  logic        acc_sel_i,
    input  logic        frac_i,
    input  logic        opnd_sel_i,
    input  logic [15:0] operand_i,
    input  logic        shl_i,
    input  logic        by4_i,
    input  logic        rd_sel_i,
    output logic [35:0] acc_o,
    output logic [15:0] acc_hi_o
);

    localparam int NACC = 2;

    op_e                     op;
    shift_ctl_t              sh;
    logic [DW-1:0]           x_q;
    logic [DW-1:0]           y_q;
    logic [PW-1:0]           prod_q;
    logic [NACC-1:0][AW-1:0] acc_bus;

    assign op      = op_e'(op_i);
    assign sh.left = shl_i;
    assign sh.by4  = by4_i;

    dsp_mul_stage u_mul (
        .clk     (clk),
        .rst     (rst),
        .load_en (op == OP_LOAD),
        .load_y  (opnd_sel_i),
        .operand (operand_i),
        .mul_en  (op == OP_MUL || op == OP_MACMUL),
        .frac    (frac_i),
        .x_q     (x_q),
        .y_q     (y_q),
        .prod_q  (prod_q)
    );

    dsp_acc_bank #(.NACC(NACC)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .op    (op),
        .sel   (acc_sel_i),
        .prod  (prod_q),
        .sh    (sh),
        .acc_o (acc_bus)
    );

    assign acc_o    = acc_bus[rd_sel_i];
    assign acc_hi_o = acc_o[PW-1:DW];

endmodule

// File: rtl/dsp_mac_checker.sv
module dsp_mac_checker (
    input logic        clk,
    input logic        rst,
    input logic [2:0]  op,
    input logic        acc_sel,
    input logic [15:0] x_q,
    input logic [15:0] y_q,
    input logic [31:0] prod_q,
    input logic [35:0] acc0,
    input logic [35:0] acc1
);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (acc0 == '0 && acc1 == '0 && prod_q == '0 && x_q == '0 && y_q == '0));

    a_r9_prod_only_on_mul: assert property (@(posedge clk) disable iff (rst)
        !(op == 3'd2 || op == 3'd7) |=> $stable(prod_q));

    a_r4_square_nonneg: assert property (@(posedge clk) disable iff (rst)
        (op == 3'd2 && x_q == y_q) |=> !prod_q[31]);

    a_r6_a1_untouched: assert property (@(posedge clk) disable iff (rst)
        !acc_sel |=> $stable(acc1));

    a_r6_a0_untouched: assert property (@(posedge clk) disable iff (rst)
        acc_sel |=> $stable(acc0));

    a_r9_uses_old_product: assert property (@(posedge clk) disable iff (rst)
        (op == 3'd7 && !acc_sel) |=>
            acc0 == $past(acc0) + {{4{$past(prod_q[31])}}, $past(prod_q)});

    a_r10_clear_a1: assert property (@(posedge clk) disable iff (rst)
        (op == 3'd6 && acc_sel) |=> acc1 == '0);

endmodule

bind dsp_mac_datapath dsp_mac_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .op      (op_i),
    .acc_sel (acc_sel_i),
    .x_q     (x_q),
    .y_q     (y_q),
    .prod_q  (prod_q),
    .acc0    (acc_bus[0]),
    .acc1    (acc_bus[1])
);

// File: tb/dsp_mac_datapath_tb.sv
module dsp_mac_datapath_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  op_i = 3'd0;
    logic        acc_sel_i = 1'b0;
    logic        frac_i = 1'b0;
    logic        opnd_sel_i = 1'b0;
    logic [15:0] operand_i = 16'h0;
    logic        shl_i = 1'b0;
    logic        by4_i = 1'b0;
    logic        rd_sel_i = 1'b0;
    logic [35:0] acc_o;
    logic [15:0] acc_hi_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    dsp_mac_datapath u_dut (
        .clk(clk), .rst(rst), .op_i(op_i), .acc_sel_i(acc_sel_i), .frac_i(frac_i),
        .opnd_sel_i(opnd_sel_i), .operand_i(operand_i), .shl_i(shl_i), .by4_i(by4_i),
        .rd_sel_i(rd_sel_i), .acc_o(acc_o), .acc_hi_o(acc_hi_o)
    );

    // apply one operation at the coming edge; returns on the next falling edge
    task automatic issue(input logic [2:0] op, input logic sel);
        op_i = op;
        acc_sel_i = sel;
        @(negedge clk);
        op_i = 3'd0;
    endtask

    task automatic load(input logic ysel, input logic [15:0] v);
        opnd_sel_i = ysel;
        operand_i = v;
        issue(3'd1, 1'b0);
    endtask

    task automatic shift(input logic sel, input logic left, input logic four);
        shl_i = left;
        by4_i = four;
        issue(3'd5, sel);
    endtask

    task automatic check(input logic sel, input logic [35:0] exp, input string req);
        rd_sel_i = sel;
        #1;
        checks++;
        if (acc_o !== exp) begin
            errors++;
            $display("FAIL %s A%0d: got %h expected %h", req, sel, acc_o, exp);
        end
        checks++;
        if (acc_hi_o !== exp[31:16]) begin
            errors++;
            $display("FAIL R11 (%s) A%0d high word: got %h expected %h", req, sel, acc_hi_o, exp[31:16]);
        end
    endtask

    task automatic t_reset();
        check(1'b0, 36'h0, "R1");
        check(1'b1, 36'h0, "R1");
        issue(3'd3, 1'b0);            // product register was cleared
        check(1'b0, 36'h0, "R1");
    endtask

    task automatic t_integer();
        frac_i = 1'b0;
        load(1'b0, 16'd3);
        load(1'b1, 16'hFFFB);         // -5
        issue(3'd2, 1'b0);
        issue(3'd6, 1'b0);
        issue(3'd3, 1'b0);
        check(1'b0, 36'hFFFFFFFF1, "R3");
        issue(3'd4, 1'b1);            // A1 = 0 - (-15)
        check(1'b1, 36'h00000000F, "R5");
        check(1'b0, 36'hFFFFFFFF1, "R6");
    endtask

    task automatic t_operand_ignored();
        operand_i = 16'h7FFF;
        opnd_sel_i = 1'b0;
        @(negedge clk);
        issue(3'd2, 1'b0);
        issue(3'd6, 1'b0);
        issue(3'd3, 1'b0);
        check(1'b0, 36'hFFFFFFFF1, "R2");
    endtask

    task automatic t_fractional();
        frac_i = 1'b1;
        load(1'b0, 16'h4000);
        load(1'b1, 16'h4000);
        issue(3'd2, 1'b0);
        issue(3'd6, 1'b0);
        issue(3'd3, 1'b0);
        check(1'b0, 36'h020000000, "R4");
        load(1'b0, 16'h8000);
        issue(3'd2, 1'b0);            // -1.0 * 0.5
        issue(3'd6, 1'b0);
        issue(3'd3, 1'b0);
        check(1'b0, 36'hFC0000000, "R4");
        load(1'b1, 16'h8000);
        issue(3'd2, 1'b0);            // clamped corner
        issue(3'd6, 1'b0);
        issue(3'd3, 1'b0);
        check(1'b0, 36'h07FFFFFFF, "R4");
    endtask

    task automatic t_left_and_wrap();
        // A0 = 0x07FFFFFFF, product still 0x7FFFFFFF
        shift(1'b0, 1'b1, 1'b1);
        check(1'b0, 36'h7FFFFFFF0, "R8");
        issue(3'd3, 1'b0);
        check(1'b0, 36'h87FFFFFEF, "R5");
        shift(1'b0, 1'b1, 1'b1);
        check(1'b0, 36'h7FFFFFEF0, "R8");
        shift(1'b0, 1'b1, 1'b0);
        check(1'b0, 36'hFFFFFFDE0, "R8");
        check(1'b1, 36'h00000000F, "R6");
    endtask

    task automatic t_right();
        frac_i = 1'b0;
        load(1'b0, 16'd32);
        load(1'b1, 16'd1);
        issue(3'd2, 1'b0);
        issue(3'd6, 1'b1);
        issue(3'd4, 1'b1);
        check(1'b1, 36'hFFFFFFFE0, "R5");
        shift(1'b1, 1'b0, 1'b0);
        check(1'b1, 36'hFFFFFFFF0, "R7");
        shift(1'b1, 1'b0, 1'b1);
        check(1'b1, 36'hFFFFFFFFF, "R7");
        load(1'b0, 16'h0100);
        load(1'b1, 16'h0100);
        issue(3'd2, 1'b0);
        issue(3'd6, 1'b0);
        issue(3'd3, 1'b0);
        shift(1'b0, 1'b0, 1'b1);
        check(1'b0, 36'h000001000, "R7");
        shift(1'b0, 1'b0, 1'b0);
        check(1'b0, 36'h000000800, "R7");
    endtask

    task automatic t_pipeline();
        frac_i = 1'b0;
        load(1'b0, 16'd2);
        load(1'b1, 16'd3);
        issue(3'd2, 1'b0);
        load(1'b0, 16'd10);
        load(1'b1, 16'd10);
        issue(3'd6, 1'b0);
        issue(3'd7, 1'b0);
        check(1'b0, 36'd6, "R9");
        issue(3'd3, 1'b0);
        check(1'b0, 36'd106, "R9");
    endtask

    task automatic t_high_word();
        load(1'b0, 16'h1234);
        load(1'b1, 16'h0100);
        issue(3'd2, 1'b0);
        issue(3'd6, 1'b0);
        issue(3'd3, 1'b0);
        check(1'b0, 36'h000123400, "R11");
    endtask

    task automatic t_clear();
        issue(3'd6, 1'b0);
        check(1'b0, 36'h0, "R10");
        check(1'b1, 36'hFFFFFFFFF, "R10");
        issue(3'd0, 1'b1);
        check(1'b1, 36'hFFFFFFFFF, "R10");
        issue(3'd6, 1'b1);
        check(1'b1, 36'h0, "R10");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_integer();
        t_operand_ignored();
        t_fractional();
        t_left_and_wrap();
        t_right();
        t_pipeline();
        t_high_word();
        t_clear();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule